// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides when a small processor core leaves its instruction stream to enter an interrupt handler. It then carries out the entry sequence. Seven sources can start an entry: three internal traps, a software interrupt, an edge-triggered urgent request, a maskable level request and a single-step trap. A fixed priority picks one source per decision, and each source is mapped to an 8-bit type number. The one exception is the maskable request, whose type byte comes from an external interrupt controller through an acknowledge handshake.

For every entry the block asks a stack stub to push the flags word. It then clears the interrupt-enable and single-step flags and presents a 20-bit handler-table address equal to the type times four. A return request asks the stub to pop a flags word and restores both flags from it. The core tells the block when an instruction has just finished. Stack memory, instruction decode and the handler fetch all belong to the surrounding core.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous reset the block is idle: `busy`, `ack_out`, `push_req`, `pop_req` and `vec_valid` are 0, and both `ien_flag` and `step_flag` are 0.
- R2: While idle, a pulse on `ien_set` makes `ien_flag` 1 and a pulse on `ien_clr` makes it 0. `step_set` and `step_clr` act on `step_flag` the same way. While `ien_flag` is 0, `mreq` starts no entry.
- R3: When `mreq` is high, `ien_flag` is 1 and `insn_done` is high, the block raises `ack_out` and holds it until `ack_vld`. It uses the byte on `ack_type` as the type, so the table address is `ack_type`×4.
- R4: A rising edge on `urgent_in` is latched until it is serviced, whatever the state of `ien_flag`. It is serviced at an instruction boundary with type 2 (address 0x00008). A level that stays high does not start a second entry.
- R5: The priority, highest first, is `div_fault`, `swi_stb`, `brk_stb`, `ovf_stb`, the latched urgent request, `mreq`, then the single-step trap. Only the winner is serviced, and a latched urgent request that loses stays pending.
- R6: The fixed types are: divide fault 0, single-step 1, breakpoint 3 and overflow 4. A software interrupt uses the 8-bit `swi_type`, and any value from 0 to 255 is allowed.
- R7: Each entry first raises `push_req` with `push_data` equal to `flags_in`, except that bit 9 holds `ien_flag` and bit 8 holds `step_flag` as they stood when the entry was taken. `push_req` and `push_data` stay steady until `push_done`.
- R8: On the cycle after `push_done`, `vec_valid` is high for exactly one cycle. `vec_addr` then holds the type in bits 9:2, with bits 19:10 and 1:0 at zero, and `ien_flag` and `step_flag` are both 0.
- R9: When `step_flag` is 1 at an instruction boundary and no other source wins, a type-1 entry starts. The flags word it pushes has bit 8 set.
- R10: A `ret_req` pulse while idle raises `pop_req` until `pop_done`. On that edge `ien_flag` takes `pop_data` bit 9 and `step_flag` takes `pop_data` bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | An instruction has just finished (boundary) |
| mreq | input | 1 | Maskable level request |
| urgent_in | input | 1 | Non-maskable request, rising-edge sensitive |
| div_fault | input | 1 | Divide-fault strobe |
| swi_stb | input | 1 | Software-interrupt strobe |
| swi_type | input | 8 | Type carried by the software interrupt |
| brk_stb | input | 1 | Breakpoint strobe |
| ovf_stb | input | 1 | Overflow-trap strobe |
| ien_set | input | 1 | Set the interrupt-enable flag |
| ien_clr | input | 1 | Clear the interrupt-enable flag |
| step_set | input | 1 | Set the single-step flag |
| step_clr | input | 1 | Clear the single-step flag |
| flags_in | input | 16 | Remaining flag bits from the core |
| ack_out | output | 1 | Acknowledge to the interrupt controller |
| ack_vld | input | 1 | Controller has placed a type byte |
| ack_type | input | 8 | Type byte from the controller |
| push_req | output | 1 | Request a flags push |
| push_data | output | 16 | Flags word to push |
| push_done | input | 1 | Push completed |
| ret_req | input | 1 | Return-from-interrupt request |
| pop_req | output | 1 | Request a flags pop |
| pop_data | input | 16 | Popped flags word |
| pop_done | input | 1 | Pop completed |
| vec_valid | output | 1 | Handler table address is valid |
| vec_addr | output | 20 | Handler table address |
| ien_flag | output | 1 | Interrupt-enable flag |
| step_flag | output | 1 | Single-step flag |
| busy | output | 1 | A sequence is in progress |

## Verification
A wrong priority or a wrong type map shows up on `vec_addr` in the cycle after `push_done`. It also shows two cycles earlier as a missing or unexpected `ack_out`. A flag that is updated in the wrong cycle shows up in bits 9 and 8 of `push_data` in the first push cycle. If the flags are not cleared, this is visible on `ien_flag` and `step_flag` while `vec_valid` is high. A broken urgent-request latch is caught one boundary later, either as a lost entry or as a second entry.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_ACK, ST_PUSH, ST_VEC, ST_POP} seq_state_t;
  typedef enum logic [2:0] {
    SRC_NONE, SRC_DIV, SRC_SWI, SRC_BRK, SRC_OVF, SRC_URG, SRC_MASK, SRC_STEP
  } src_t;
  localparam int IEN_BIT  = 9;
  localparam int STEP_BIT = 8;
  localparam logic [7:0] TYPE_DIV  = 8'd0;
  localparam logic [7:0] TYPE_STEP = 8'd1;
  localparam logic [7:0] TYPE_URG  = 8'd2;
  localparam logic [7:0] TYPE_BRK  = 8'd3;
  localparam logic [7:0] TYPE_OVF  = 8'd4;
endpackage

// File: rtl/irq_urgent_latch.sv
module irq_urgent_latch (
  input  logic clk,
  input  logic rst,
  input  logic urgent_in,
  input  logic clr,
  output logic pend
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= urgent_in;
      if (urgent_in && !prev_q) pend <= 1'b1;
      else if (clr)             pend <= 1'b0;
    end
  end

  // R4: a rising edge is always latched
  p_edge_latched_r4: assert property (@(posedge clk) disable iff (rst)
    (urgent_in && !prev_q) |=> pend);
endmodule

// File: rtl/irq_src_arbiter.sv
module irq_src_arbiter
  import irq_entry_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic              insn_done,
  input  logic              div_fault,
  input  logic              swi_stb,
  input  logic [TYPE_W-1:0] swi_type,
  input  logic              brk_stb,
  input  logic              ovf_stb,
  input  logic              urg_pend,
  input  logic              mreq,
  input  logic              ien,
  input  logic              step,
  output src_t              src,
  output logic [TYPE_W-1:0] src_type
);
  always_comb begin
    src      = SRC_NONE;
    src_type = '0;
    if (div_fault) begin
      src = SRC_DIV;  src_type = TYPE_W'(TYPE_DIV);
    end else if (swi_stb) begin
      src = SRC_SWI;  src_type = swi_type;
    end else if (brk_stb) begin
      src = SRC_BRK;  src_type = TYPE_W'(TYPE_BRK);
    end else if (ovf_stb) begin
      src = SRC_OVF;  src_type = TYPE_W'(TYPE_OVF);
    end else if (insn_done && urg_pend) begin
      src = SRC_URG;  src_type = TYPE_W'(TYPE_URG);
    end else if (insn_done && mreq && ien) begin
      src = SRC_MASK; src_type = '0;
    end else if (insn_done && step) begin
      src = SRC_STEP; src_type = TYPE_W'(TYPE_STEP);
    end
  end

  // R2: the maskable source never wins while enable is low
  always_comb begin
    p_mask_needs_ien_r2: assert (src != SRC_MASK || ien);
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int ADDR_W = 20,
  parameter int FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_done,
  input  logic              mreq,
  input  logic              urgent_in,
  input  logic              div_fault,
  input  logic              swi_stb,
  input  logic [TYPE_W-1:0] swi_type,
  input  logic              brk_stb,
  input  logic              ovf_stb,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic              step_set,
  input  logic              step_clr,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              ack_out,
  input  logic              ack_vld,
  input  logic [TYPE_W-1:0] ack_type,
  output logic              push_req,
  output logic [FLAG_W-1:0] push_data,
  input  logic              push_done,
  input  logic              ret_req,
  output logic              pop_req,
  input  logic [FLAG_W-1:0] pop_data,
  input  logic              pop_done,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              ien_flag,
  output logic              step_flag,
  output logic              busy
);
  localparam int PAD_W = ADDR_W - TYPE_W - 2;

  seq_state_t        state_q;
  src_t              src;
  logic [TYPE_W-1:0] src_type, type_q;
  logic              urg_pend, urg_clr;
  logic [FLAG_W-1:0] word_now;

  irq_urgent_latch u_urg (
    .clk(clk), .rst(rst), .urgent_in(urgent_in), .clr(urg_clr), .pend(urg_pend)
  );

  irq_src_arbiter #(.TYPE_W(TYPE_W)) u_arb (
    .insn_done(insn_done), .div_fault(div_fault), .swi_stb(swi_stb),
    .swi_type(swi_type), .brk_stb(brk_stb), .ovf_stb(ovf_stb),
    .urg_pend(urg_pend), .mreq(mreq), .ien(ien_flag), .step(step_flag),
    .src(src), .src_type(src_type)
  );

  assign urg_clr = (state_q == ST_IDLE) && (src == SRC_URG);

  always_comb begin
    word_now           = flags_in;
    word_now[IEN_BIT]  = ien_flag;
    word_now[STEP_BIT] = step_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      type_q    <= '0;
      push_data <= '0;
      vec_addr  <= '0;
      ien_flag  <= 1'b0;
      step_flag <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (src != SRC_NONE) begin
            type_q    <= src_type;
            push_data <= word_now;
            state_q   <= (src == SRC_MASK) ? ST_ACK : ST_PUSH;
          end else if (ret_req) begin
            state_q <= ST_POP;
          end else begin
            if (ien_set)       ien_flag  <= 1'b1;
            else if (ien_clr)  ien_flag  <= 1'b0;
            if (step_set)      step_flag <= 1'b1;
            else if (step_clr) step_flag <= 1'b0;
          end
        end
        ST_ACK: begin
          if (ack_vld) begin
            type_q  <= ack_type;
            state_q <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (push_done) begin
            ien_flag  <= 1'b0;
            step_flag <= 1'b0;
            vec_addr  <= {{PAD_W{1'b0}}, type_q, 2'b00};
            state_q   <= ST_VEC;
          end
        end
        ST_VEC: state_q <= ST_IDLE;
        ST_POP: begin
          if (pop_done) begin
            ien_flag  <= pop_data[IEN_BIT];
            step_flag <= pop_data[STEP_BIT];
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_out   = (state_q == ST_ACK);
  assign push_req  = (state_q == ST_PUSH);
  assign pop_req   = (state_q == ST_POP);
  assign vec_valid = (state_q == ST_VEC);
  assign busy      = (state_q != ST_IDLE);

  // R2: acknowledge starts only after enable was set
  p_ack_needs_ien_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_out) |-> $past(ien_flag));
  // R3: acknowledge is held until the type byte arrives
  p_ack_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ack_out && !ack_vld) |=> ack_out);
  // R7: push request and word stay steady until done
  p_push_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (push_req && !push_done) |=> (push_req && $stable(push_data)));
  // R8: flags are clear while the address is presented
  p_vec_flags_clear_r8: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (!ien_flag && !step_flag));
  // R8: the address strobe lasts one cycle
  p_vec_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);
  // R10: pop request is held until done
  p_pop_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !pop_done) |=> pop_req);
endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] FLAGS = 16'hF0C3;

  // entry: kind[31:29] type[28:21] addr[20:1] step[0]
  // kind: 0 div, 1 swi, 2 brk, 3 ovf, 4 urgent, 5 maskable, 6 single-step
  localparam logic [31:0] TBL [0:8] = '{
    {3'd0, 8'h00, 20'h00000, 1'b0},
    {3'd1, 8'h21, 20'h00084, 1'b0},
    {3'd1, 8'hFF, 20'h003FC, 1'b0},
    {3'd2, 8'h00, 20'h0000C, 1'b0},
    {3'd3, 8'h00, 20'h00010, 1'b0},
    {3'd4, 8'h00, 20'h00008, 1'b0},
    {3'd5, 8'h08, 20'h00020, 1'b0},
    {3'd5, 8'hC0, 20'h00300, 1'b0},
    {3'd6, 8'h00, 20'h00004, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic insn_done = 0, mreq = 0, urgent_in = 0, div_fault = 0, swi_stb = 0;
  logic brk_stb = 0, ovf_stb = 0, ien_set = 0, ien_clr = 0, step_set = 0, step_clr = 0;
  logic [7:0] swi_type = '0, ack_type = '0;
  logic ack_vld = 0, push_done = 0, ret_req = 0, pop_done = 0;
  logic [15:0] pop_data = '0;
  logic ack_out, push_req, pop_req, vec_valid, ien_flag, step_flag, busy;
  logic [15:0] push_data;
  logic [19:0] vec_addr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  irq_entry_seq uut (
    .clk(clk), .rst(rst), .insn_done(insn_done), .mreq(mreq), .urgent_in(urgent_in),
    .div_fault(div_fault), .swi_stb(swi_stb), .swi_type(swi_type), .brk_stb(brk_stb),
    .ovf_stb(ovf_stb), .ien_set(ien_set), .ien_clr(ien_clr), .step_set(step_set),
    .step_clr(step_clr), .flags_in(FLAGS), .ack_out(ack_out), .ack_vld(ack_vld),
    .ack_type(ack_type), .push_req(push_req), .push_data(push_data),
    .push_done(push_done), .ret_req(ret_req), .pop_req(pop_req), .pop_data(pop_data),
    .pop_done(pop_done), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .ien_flag(ien_flag), .step_flag(step_flag), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_flags(input logic ien, input logic stp);
    tick();
    ien_set = ien; ien_clr = !ien; step_set = stp; step_clr = !stp;
    tick();
    ien_set = 0; ien_clr = 0; step_set = 0; step_clr = 0;
  endtask

  // called at the negedge where the push cycle is expected
  task automatic finish_entry(input string tag, input logic [15:0] word, input logic [19:0] addr);
    check({tag, " R7 push_req"}, 32'(push_req), 32'd1);
    check({tag, " R7 push_data"}, 32'(push_data), 32'(word));
    tick();
    check({tag, " R7 push held"}, 32'(push_req), 32'd1);
    push_done = 1;
    tick();
    push_done = 0;
    check({tag, " R8 vec_valid"}, 32'(vec_valid), 32'd1);
    check({tag, " R6 vec_addr"}, 32'(vec_addr), 32'(addr));
    check({tag, " R8 flags cleared"}, {30'd0, ien_flag, step_flag}, 32'd0);
    tick();
    check({tag, " R8 vec one cycle"}, {30'd0, vec_valid, busy}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    check("R1 idle outputs", {27'd0, busy, ack_out, push_req, pop_req, vec_valid}, 32'd0);
    check("R1 flags", {30'd0, ien_flag, step_flag}, 32'd0);

    // table of entries
    for (int i = 0; i < 9; i++) begin
      logic [2:0]  k  = TBL[i][31:29];
      logic [7:0]  ty = TBL[i][28:21];
      logic [19:0] ad = TBL[i][20:1];
      logic        st = TBL[i][0];
      logic [15:0] w  = FLAGS | 16'h0200 | (st ? 16'h0100 : 16'h0000);
      set_flags(1'b1, st);
      check("R2 ien set", 32'(ien_flag), 32'd1);
      case (k)
        3'd0: div_fault = 1;
        3'd1: begin swi_stb = 1; swi_type = ty; end
        3'd2: brk_stb = 1;
        3'd3: ovf_stb = 1;
        3'd4: urgent_in = 1;
        3'd5: begin mreq = 1; insn_done = 1; end
        default: insn_done = 1;
      endcase
      if (k == 3'd4) begin tick(); insn_done = 1; end
      tick();
      div_fault = 0; swi_stb = 0; brk_stb = 0; ovf_stb = 0; insn_done = 0; urgent_in = 0;
      if (k == 3'd5) begin
        check("R3 ack raised", 32'(ack_out), 32'd1);
        tick();
        check("R3 ack held", 32'(ack_out), 32'd1);
        ack_vld = 1; ack_type = ty;
        tick();
        ack_vld = 0; mreq = 0;
      end
      finish_entry($sformatf("R6 entry %0d", i), w, ad);
    end

    // R2: maskable request ignored while enable is low
    set_flags(1'b0, 1'b0);
    mreq = 1; insn_done = 1;
    repeat (3) tick();
    check("R2 masked no ack", {30'd0, ack_out, busy}, 32'd0);
    mreq = 0; insn_done = 0;

    // R4: urgent request served with enable low; held level does not retrigger
    urgent_in = 1;
    tick(); insn_done = 1;
    tick(); insn_done = 0;
    finish_entry("R4 urgent ien=0", FLAGS, 20'h00008);
    insn_done = 1;
    repeat (2) tick();
    check("R4 level no retrigger", 32'(busy), 32'd0);
    insn_done = 0; urgent_in = 0;

    // R4/R5: latched urgent request waits behind a divide fault, then is served
    tick(); urgent_in = 1;
    tick(); urgent_in = 0;
    repeat (3) tick();
    check("R4 latched not yet served", 32'(busy), 32'd0);
    div_fault = 1; insn_done = 1;
    tick(); div_fault = 0;
    finish_entry("R5 divide beats urgent", FLAGS, 20'h00000);
    tick(); insn_done = 0;
    finish_entry("R4 pending urgent served", FLAGS, 20'h00008);

    // R5: urgent beats maskable with enable set
    set_flags(1'b1, 1'b0);
    mreq = 1; urgent_in = 1;
    tick(); insn_done = 1;
    tick(); insn_done = 0; urgent_in = 0;
    check("R5 no ack when urgent wins", 32'(ack_out), 32'd0);
    mreq = 0;
    finish_entry("R5 urgent over maskable", FLAGS | 16'h0200, 20'h00008);

    // R5/R9: maskable beats single-step; pushed word carries step bit
    set_flags(1'b1, 1'b1);
    mreq = 1; insn_done = 1;
    tick(); insn_done = 0;
    check("R5 maskable over step", 32'(ack_out), 32'd1);
    ack_vld = 1; ack_type = 8'h55;
    tick(); ack_vld = 0; mreq = 0;
    finish_entry("R9 step bit pushed", FLAGS | 16'h0300, 20'h00154);

    // R10: return restores both flags from the popped word
    tick(); ret_req = 1;
    tick(); ret_req = 0;
    check("R10 pop_req", 32'(pop_req), 32'd1);
    tick();
    check("R10 pop held", 32'(pop_req), 32'd1);
    pop_data = 16'h0200; pop_done = 1;
    tick(); pop_done = 0;
    check("R10 restore ien=1 step=0", {29'd0, ien_flag, step_flag, busy}, 32'b100);
    ret_req = 1;
    tick(); ret_req = 0;
    pop_data = 16'hFDFF; pop_done = 1;
    tick(); pop_done = 0;
    check("R10 restore ien=0 step=1", {29'd0, ien_flag, step_flag, busy}, 32'b010);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule